// File: doc/BRIEF.md
# SMT Commit Thread Selector

In a core that runs several hardware threads at once, each commit slot can retire the head of only one thread's reorder buffer. This block decides which thread that is. For every thread it reads a commit status code, a flag that says the oldest buffered instruction is ready, a flag that says the buffer holds nothing, and the sequence number of the head instruction. It answers with a valid flag and a thread index. The answer is combinational, so the commit loop can ask once per slot. The loop pulses a take strobe when it actually retires the granted head.

A static two-bit policy input picks the arbitration rule. In rotating mode, the block keeps an ordered list of threads. It grants the first thread in that list that is ready. After an accepted grant, the winner moves to the back of the list. In age mode, the block compares the head sequence numbers of all eligible threads and grants the oldest one. When the core is built with a single thread, the status code alone decides the answer.

Top module: `smt_commit_sel`

## Requirements
- R1: Status codes are 3 bits: 0 = running, 1 = idle, 2 = squashing, 3 = trap wait, 4 = fetch-trap wait, and 5 to 7 unused. In rotating mode a thread is eligible only when its status is 0 or 1 and its head-ready bit is 1.
- R2: In rotating mode the grant goes to the first eligible thread in the current priority list order.
- R3: When the take strobe is high, the output is valid and the mode is rotating, the granted thread moves to the tail of the list at the next clock edge. The other threads shift forward and keep their relative order.
- R4: The list does not change on a cycle without an accepted rotating-mode grant. This covers take low, output invalid, and take high in age mode.
- R5: After reset the priority list is in ascending thread index order, 0 first.
- R6: In age mode a thread is eligible only when its buffer-empty bit is 0, its status is 0, 1 or 4, and its head-ready bit is 1. The eligible thread with the numerically smallest head sequence number wins.
- R7: In age mode, when eligible threads have equal sequence numbers, the lowest thread index wins.
- R8: When no thread is eligible, sel_vld_o is 0 and sel_tid_o is 0.
- R9: With one thread configured, the output is valid exactly when the status is 0, 1 or 4. The ready and empty bits and the policy have no effect.
- R10: Policy codes are 2'b00 for rotating and 2'b01 for age. Code 2'b10 (aggressive) selects exactly as age mode does, and so does 2'b11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| policy_i | input | 2 | Static arbitration policy code |
| status_i | input | NT*3 | Per-thread commit status, thread t in bits [3t+2:3t] |
| head_rdy_i | input | NT | Per-thread head-ready flag |
| rob_empty_i | input | NT | Per-thread reorder-buffer empty flag |
| head_seq_i | input | NT*SEQ_W | Per-thread head sequence number |
| grant_take_i | input | 1 | Strobe: the current grant is being retired this cycle |
| sel_vld_o | output | 1 | A thread is granted |
| sel_tid_o | output | TID_W | Granted thread index |

## Verification
On every cycle, the embedded properties check several things. A rotating grant always names a thread that is ready and in a running or idle state. An age grant never passes over an older eligible head or a lower-index tie. An invalid output always carries index zero. The priority list always stays a permutation: it moves the winner to the tail only on an accepted grant and holds still otherwise. Only the bench scenarios can show the complete order in which the list grants across a sequence of strobes, that reset leaves the order ascending, and that the three age-style policy codes agree with one another. The single-thread build, and its indifference to the ready and empty bits, is swept separately.

// File: rtl/smt_sel_pkg.sv
package smt_sel_pkg;

  typedef enum logic [2:0] {
    CS_RUN        = 3'd0,
    CS_IDLE       = 3'd1,
    CS_SQUASH     = 3'd2,
    CS_TRAP_WAIT  = 3'd3,
    CS_FTRAP_WAIT = 3'd4
  } commit_st_e;

  localparam logic [1:0] POL_ROTATE = 2'b00;
  localparam logic [1:0] POL_AGE    = 2'b01;
  localparam logic [1:0] POL_AGGR   = 2'b10;

  // Statuses that may commit under the rotating rule.
  function automatic logic rotate_status_ok(input logic [2:0] s);
    return (s == CS_RUN) || (s == CS_IDLE);
  endfunction

  // Statuses that may commit under the age rule (and single-thread mode).
  function automatic logic age_status_ok(input logic [2:0] s);
    return (s == CS_RUN) || (s == CS_IDLE) || (s == CS_FTRAP_WAIT);
  endfunction

endpackage

// File: rtl/smt_sel_elig.sv
module smt_sel_elig
  import smt_sel_pkg::*;
#(
  parameter int NT = 4
) (
  input  logic [NT-1:0][2:0] status_i,
  input  logic [NT-1:0]      head_rdy_i,
  input  logic [NT-1:0]      rob_empty_i,
  output logic [NT-1:0]      rot_elig_o,
  output logic [NT-1:0]      age_elig_o,
  output logic [NT-1:0]      st_only_o
);

  for (genvar t = 0; t < NT; t++) begin : g_thr
    assign st_only_o[t]  = age_status_ok(status_i[t]);
    assign rot_elig_o[t] = rotate_status_ok(status_i[t]) & head_rdy_i[t];
    assign age_elig_o[t] = st_only_o[t] & head_rdy_i[t] & ~rob_empty_i[t];
  end

endmodule

// File: rtl/smt_sel_rotate.sv
module smt_sel_rotate #(
  parameter int NT    = 4,
  parameter int TID_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NT-1:0]    elig_i,
  input  logic             take_i,
  output logic             vld_o,
  output logic [TID_W-1:0] tid_o
);

  logic [NT-1:0][TID_W-1:0] order_q, order_d;
  logic [TID_W-1:0]         pos;
  logic                     adv_en;

  // Pick: first eligible entry in list order.
  always_comb begin
    vld_o = 1'b0;
    tid_o = '0;
    pos   = '0;
    for (int p = 0; p < NT; p++) begin
      if (!vld_o && elig_i[order_q[p]]) begin
        vld_o = 1'b1;
        tid_o = order_q[p];
        pos   = TID_W'(p);
      end
    end
  end

  assign adv_en = take_i & vld_o;

  // Next list: close the gap at pos, append winner at the tail.
  always_comb begin
    order_d = order_q;
    for (int i = 0; i < NT - 1; i++) begin
      if (TID_W'(i) >= pos) order_d[i] = order_q[i+1];
    end
    order_d[NT-1] = tid_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NT; i++) order_q[i] <= TID_W'(i);
    end else if (adv_en) begin
      order_q <= order_d;
    end
  end

  logic [NT-1:0] present;
  always_comb begin
    present = '0;
    for (int i = 0; i < NT; i++) present[order_q[i]] = 1'b1;
  end

  assert_list_perm_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(present) == NT);

  assert_winner_tail_R3: assert property (@(posedge clk) disable iff (!rst_n)
    adv_en |=> order_q[NT-1] == $past(tid_o));

  assert_list_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !adv_en |=> $stable(order_q));

  assert_pick_elig_R2: assert property (@(posedge clk) disable iff (!rst_n)
    vld_o |-> elig_i[tid_o]);

endmodule

// File: rtl/smt_sel_age.sv
module smt_sel_age #(
  parameter int NT    = 4,
  parameter int SEQ_W = 16,
  parameter int TID_W = 2
) (
  input  logic [NT-1:0]            elig_i,
  input  logic [NT-1:0][SEQ_W-1:0] seq_i,
  output logic                     vld_o,
  output logic [TID_W-1:0]         tid_o
);

  logic [SEQ_W-1:0] best;

  // Strictly-smaller replacement keeps the lowest index on ties.
  always_comb begin
    vld_o = 1'b0;
    tid_o = '0;
    best  = '0;
    for (int i = 0; i < NT; i++) begin
      if (elig_i[i] && (!vld_o || seq_i[i] < best)) begin
        vld_o = 1'b1;
        tid_o = TID_W'(i);
        best  = seq_i[i];
      end
    end
  end

endmodule

// File: rtl/smt_commit_sel.sv
module smt_commit_sel
  import smt_sel_pkg::*;
#(
  parameter int  NT    = 4,
  parameter int  SEQ_W = 16,
  localparam int TID_W = (NT > 1) ? $clog2(NT) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          policy_i,
  input  logic [NT*3-1:0]     status_i,
  input  logic [NT-1:0]       head_rdy_i,
  input  logic [NT-1:0]       rob_empty_i,
  input  logic [NT*SEQ_W-1:0] head_seq_i,
  input  logic                grant_take_i,
  output logic                sel_vld_o,
  output logic [TID_W-1:0]    sel_tid_o
);

  // Reset: asynchronous assert, synchronous release.
  logic [1:0] rsync_q;
  logic       rst_core_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_core_n = rsync_q[1];

  logic [NT-1:0][2:0]       st_a;
  logic [NT-1:0][SEQ_W-1:0] seq_a;
  logic [NT-1:0]            rot_elig, age_elig, st_only;
  logic                     use_rot;

  assign st_a    = status_i;
  assign seq_a   = head_seq_i;
  assign use_rot = (policy_i == POL_ROTATE);

  smt_sel_elig #(.NT(NT)) u_elig (
    .status_i    (st_a),
    .head_rdy_i  (head_rdy_i),
    .rob_empty_i (rob_empty_i),
    .rot_elig_o  (rot_elig),
    .age_elig_o  (age_elig),
    .st_only_o   (st_only)
  );

  if (NT == 1) begin : g_single
    assign sel_vld_o = st_only[0];
    assign sel_tid_o = '0;

    assert_single_status_R9: assert property (@(posedge clk) disable iff (!rst_core_n)
      sel_vld_o == ((st_a[0] == CS_RUN) || (st_a[0] == CS_IDLE) || (st_a[0] == CS_FTRAP_WAIT)));
  end else begin : g_multi
    logic             rot_vld, age_vld;
    logic [TID_W-1:0] rot_tid, age_tid;

    smt_sel_rotate #(.NT(NT), .TID_W(TID_W)) u_rot (
      .clk    (clk),
      .rst_n  (rst_core_n),
      .elig_i (rot_elig),
      .take_i (grant_take_i & use_rot),
      .vld_o  (rot_vld),
      .tid_o  (rot_tid)
    );

    smt_sel_age #(.NT(NT), .SEQ_W(SEQ_W), .TID_W(TID_W)) u_age (
      .elig_i (age_elig),
      .seq_i  (seq_a),
      .vld_o  (age_vld),
      .tid_o  (age_tid)
    );

    assign sel_vld_o = use_rot ? rot_vld : age_vld;
    assign sel_tid_o = use_rot ? rot_tid : age_tid;

    logic older_seen, tie_lower;
    always_comb begin
      older_seen = 1'b0;
      tie_lower  = 1'b0;
      for (int i = 0; i < NT; i++) begin
        if (age_elig[i] && seq_a[i] < seq_a[sel_tid_o]) older_seen = 1'b1;
        if (age_elig[i] && seq_a[i] == seq_a[sel_tid_o] && TID_W'(i) < sel_tid_o)
          tie_lower = 1'b1;
      end
    end

    assert_rot_grant_ok_R1: assert property (@(posedge clk) disable iff (!rst_core_n)
      (use_rot && sel_vld_o) |->
        (((st_a[sel_tid_o] == CS_RUN) || (st_a[sel_tid_o] == CS_IDLE)) && head_rdy_i[sel_tid_o]));

    assert_age_grant_ok_R6: assert property (@(posedge clk) disable iff (!rst_core_n)
      (!use_rot && sel_vld_o) |-> (!rob_empty_i[sel_tid_o] && head_rdy_i[sel_tid_o] && !older_seen));

    assert_age_tie_low_R7: assert property (@(posedge clk) disable iff (!rst_core_n)
      (!use_rot && sel_vld_o) |-> !tie_lower);
  end

  assert_idle_zero_R8: assert property (@(posedge clk) disable iff (!rst_core_n)
    !sel_vld_o |-> (sel_tid_o == '0));

endmodule

// File: tb/sim_smt_commit_sel.sv
module sim_smt_commit_sel;

  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rst_n;
  always #(CLK_P/2) clk = ~clk;

  // Four-thread instance
  logic [1:0]       pol;
  logic [3:0][2:0]  st;
  logic [3:0]       rdy, emp;
  logic [3:0][15:0] seq;
  logic             take;
  logic             vld;
  logic [1:0]       tid;

  smt_commit_sel #(.NT(4), .SEQ_W(16)) u0 (
    .clk(clk), .rst_n(rst_n), .policy_i(pol), .status_i(st),
    .head_rdy_i(rdy), .rob_empty_i(emp), .head_seq_i(seq),
    .grant_take_i(take), .sel_vld_o(vld), .sel_tid_o(tid));

  // Single-thread instance
  logic [1:0]  pol1;
  logic [2:0]  st1;
  logic        rdy1, emp1;
  logic [15:0] seq1;
  logic        vld1;
  logic [0:0]  tid1;

  smt_commit_sel #(.NT(1), .SEQ_W(16)) u1 (
    .clk(clk), .rst_n(rst_n), .policy_i(pol1), .status_i(st1),
    .head_rdy_i(rdy1), .rob_empty_i(emp1), .head_seq_i(seq1),
    .grant_take_i(1'b0), .sel_vld_o(vld1), .sel_tid_o(tid1));

  int errors = 0;
  int checks = 0;
  int ord[4];
  logic [31:0] lfsr = 32'h1ACE_B00C;

  function automatic logic [31:0] nxt(input logic [31:0] x);
    return {x[30:0], x[31] ^ x[21] ^ x[1] ^ x[0]};
  endfunction

  task automatic check(input string req, input logic av, input int at,
                       input logic ev, input int et);
    checks++;
    if (av !== ev || at != et) begin
      errors++;
      $display("FAIL %s: got vld=%0d tid=%0d, expected vld=%0d tid=%0d",
               req, av, at, ev, et);
    end
  endtask

  // Expected grant from the requirements (R1, R2, R6, R7, R8, R10).
  task automatic expect_pick(output logic ev, output int et);
    logic [15:0] best;
    ev = 1'b0; et = 0; best = '0;
    if (pol == 2'b00) begin
      for (int p = 0; p < 4; p++) begin
        int t;
        t = ord[p];
        if (!ev && (st[t] == 3'd0 || st[t] == 3'd1) && rdy[t]) begin
          ev = 1'b1; et = t;
        end
      end
    end else begin
      for (int i = 0; i < 4; i++) begin
        if (!emp[i] && rdy[i] && (st[i] == 3'd0 || st[i] == 3'd1 || st[i] == 3'd4)
            && (!ev || seq[i] < best)) begin
          ev = 1'b1; et = i; best = seq[i];
        end
      end
    end
  endtask

  // Inputs already driven after a falling edge; check, then clock once.
  task automatic step(input string req);
    logic ev;
    int   et;
    #1;
    expect_pick(ev, et);
    check(req, vld, int'(tid), ev, et);
    @(posedge clk);
    if (take && ev && pol == 2'b00) begin
      for (int p = 0; p < 4; p++) begin
        if (ord[p] == et) begin
          for (int q = p; q < 3; q++) ord[q] = ord[q+1];
          ord[3] = et;
          break;
        end
      end
    end
    @(negedge clk);
  endtask

  initial begin
    #(CLK_P * 200000);
    errors++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    pol = 2'b00; st = '0; rdy = '0; emp = '0; seq = '0; take = 1'b0;
    pol1 = 2'b00; st1 = '0; rdy1 = 1'b0; emp1 = 1'b0; seq1 = '0;
    for (int i = 0; i < 4; i++) ord[i] = i;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);

    // R5: reset order is ascending; R3: successive accepted grants walk it.
    rdy = 4'hF; st = '0;
    step("R5 reset order head");
    take = 1'b1;
    for (int k = 0; k < 4; k++) step("R5 R3 ascending rotation");
    take = 1'b0;

    // R4: no rotation without take, nor with take in age mode.
    rdy = 4'b1010;
    for (int k = 0; k < 3; k++) step("R4 hold without take");
    pol = 2'b01; take = 1'b1;
    for (int k = 0; k < 3; k++) step("R4 age mode take ignored by list");
    pol = 2'b00; take = 1'b0;
    step("R4 list unchanged after age grants");

    // R8: nothing eligible under either policy.
    st = {3'd2, 3'd3, 3'd5, 3'd7}; rdy = 4'hF; emp = '0; take = 1'b1;
    step("R8 rotating none eligible");
    pol = 2'b01;
    step("R8 age none eligible");
    take = 1'b0;

    // R1 R2 R3 R4: rotating sweep with varied status, ready and take.
    pol = 2'b00;
    for (int k = 0; k < 800; k++) begin
      lfsr = nxt(lfsr);
      rdy  = lfsr[3:0];
      st   = {lfsr[6:5] == 2'b11 ? 3'd2 : {1'b0, lfsr[6:5]},
              {1'b0, lfsr[9:8]}, {2'b0, lfsr[11]}, lfsr[15:13]};
      emp  = lfsr[19:16];
      take = lfsr[20] | lfsr[21];
      step("R2 R3 rotating sweep");
    end
    take = 1'b0;

    // R6 R10: age mode, exhaustive ready x empty x status phase, policy codes 01/10/11.
    for (int c = 0; c < 8; c++) begin
      for (int r = 0; r < 16; r++) begin
        for (int e = 0; e < 16; e++) begin
          lfsr = nxt(lfsr);
          pol  = 2'(1 + ((c + r + e) % 3));
          rdy  = 4'(r);
          emp  = 4'(e);
          for (int i = 0; i < 4; i++) begin
            st[i]  = 3'((c + i * 3) % 8);
            seq[i] = lfsr[15:0] ^ 16'(i * 16'h3C51);
          end
          take = lfsr[31];
          step("R6 R10 age sweep");
        end
      end
    end
    take = 1'b0;

    // R7: equal sequence numbers pick the lowest eligible index.
    pol = 2'b01; st = '0; rdy = 4'hF; emp = '0;
    seq = {16'd42, 16'd42, 16'd42, 16'd42};
    step("R7 tie all eligible");
    rdy = 4'b1110;
    step("R7 tie lowest skips thread 0");
    seq = {16'd7, 16'd42, 16'd7, 16'd42};
    step("R7 tie between threads 1 and 3");
    seq = {16'hFFFF, 16'd0, 16'hFFFF, 16'hFFFF};
    step("R6 zero sequence oldest");

    // R9: single thread ignores ready, empty and policy.
    for (int s = 0; s < 8; s++) begin
      for (int m = 0; m < 16; m++) begin
        logic ev1;
        st1  = 3'(s);
        rdy1 = m[0]; emp1 = m[1]; pol1 = m[3:2];
        seq1 = 16'(m * 977);
        #1;
        ev1 = (s == 0 || s == 1 || s == 4);
        check("R9 single thread", vld1, int'(tid1), ev1, 0);
        @(negedge clk);
      end
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule